// File: doc/BRIEF.md
# Random Generator Control and Status Registers

This block is the register front end of a random number source. A host reaches it over a simple 32-bit register bus: one address, a read strobe, a write strobe, write data and read data. Through it the host can read a fixed identification word, start a seeding run and a self-test run, set interrupt masks and an auto-seed flag, poll a status word, and pull random words from a data port. One level-sensitive interrupt line reports finished operations.

Seeding and self-test are tracked separately. Each is idle, running or finished. A start command puts it into the running state, and it finishes after a fixed number of clock cycles set by a parameter. Busy and ready in the status word are derived from both trackers. Random words come from an internal 32-bit linear feedback shift register. It steps once for each read of the data port. There is no real entropy source, no statistical test and no output FIFO. The FIFO fields in the status word are constants.

Read data is combinational. It reflects the state present in the cycle in which the read strobe is high. Writes take effect at the clock edge that samples the write strobe.

Top module: `rng_ctrl_regs`

## Requirements
- R1: A read at offset 0x00 returns 0x1000_0240. That is type 1 in bits 31:28, major 2 in bits 15:8, minor 0x40 in bits 7:0, and zeros elsewhere.
- R2: A read at offset 0x04 (command) returns bit 1 = seeding running and bit 0 = self-test running, with all other bits zero. A command write may set several bits at once, and each one takes effect.
- R3: Control at offset 0x08 stores written bits 6 (mask error), 5 (mask done) and 4 (auto-seed) exactly as given. All other bits are dropped and read as zero.
- R4: Command bit 1 starts seeding and bit 0 starts self-test. The operation is running from the next cycle and becomes done exactly OP_LATENCY clock edges after the start edge. A start while it is running restarts the count.
- R5: A read at offset 0x0C (status) returns FIFO_WORDS in bits 15:12 and again in bits 11:8. Bit 6 is always set. Bit 5 is seeding done and bit 4 is self-test done. Bit 1 is busy (either operation running) and bit 0 is ready (neither running). All other bits are zero.
- R6: At the edge where an operation becomes done, the interrupt rises unless mask-done is set. Once high, it stays high until it is cleared.
- R7: A command write with bit 5 or bit 4 set lowers the interrupt. If a completion falls on the same edge, the interrupt stays high.
- R8: Command bit 6 (software reset) returns both operations to idle and clears all three control bits. It leaves the interrupt as it is. A start bit in the same write still starts its operation.
- R9: When rst_n is low at a clock edge, both operations become idle, control and the interrupt clear, and the generator reloads LFSR_SEED.
- R10: A read at offset 0x14 returns the generator state and then steps it. The step shifts the state left by one and fills bit 0 with the XOR of bits 31, 21, 1 and 0. After reset the state is LFSR_SEED.
- R11: Reads of unmapped offsets (for example 0x10 and 0x1C) return zero. Writes to offsets 0x00, 0x0C and 0x14 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset |
| irq_o | output | 1 | Operation-done interrupt, level |

## Verification
The bench builds the block with OP_LATENCY set to 6 and a non-default LFSR_SEED of 0xACE1_0001. The short latency puts the completion edge a few cycles after a start. Reads and interrupt samples can then land exactly one cycle before and at the finishing edge, and a restart, a clear colliding with a completion, and a software reset in mid-run all fit in a short sequence. The non-default seed shows that the generator starts from the parameter and not from a constant inside the design, both after power-up and after a reset in mid-operation.

// File: rtl/rng_ctrl_pkg.sv
// Package: shared types and register layout for the random generator front end.
// Assumes byte offsets on a 32-bit register bus; bit positions are behaviour
// the host software decodes, so they are fixed here in one place.
package rng_ctrl_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RUN  = 2'd1,
        OP_DONE = 2'd2
    } op_state_e;

    localparam int NUM_OPS   = 2;
    localparam int OP_SELFT  = 0;   // command/readback bit 0
    localparam int OP_SEED   = 1;   // command/readback bit 1

    localparam logic [7:0] OFF_IDENT  = 8'h00;
    localparam logic [7:0] OFF_CMD    = 8'h04;
    localparam logic [7:0] OFF_CTRL   = 8'h08;
    localparam logic [7:0] OFF_STAT   = 8'h0C;
    localparam logic [7:0] OFF_DATA   = 8'h14;

    localparam int CMD_SWRST   = 6;
    localparam int CMD_CLRERR  = 5;
    localparam int CMD_CLRIRQ  = 4;

    localparam int CTL_MSKERR  = 6;
    localparam int CTL_MSKDONE = 5;
    localparam int CTL_AUTOSD  = 4;

    localparam logic [31:0] IDENT_WORD = {4'h1, 12'h000, 8'h02, 8'h40};

endpackage

// File: rtl/rng_op_tracker.sv
// Module: life-cycle tracker for one long-running operation (idle/run/done).
// A start enters RUN with a cleared counter; after LATENCY edges in RUN the
// operation finishes. Assumes LATENCY >= 1. Start wins over abort.
module rng_op_tracker
    import rng_ctrl_pkg::*;
#(
    parameter int LATENCY = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      abort_i,
    output op_state_e state_o,
    output logic      done_o
);
    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LATENCY - 1);

    op_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             finish;

    // Completion condition: counter at its last value while running.
    assign finish = (state_q == OP_RUN) && (cnt_q == LAST);

    // State and counter update, start has priority, then abort, then counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OP_IDLE;
            cnt_q   <= '0;
        end else if (start_i) begin
            state_q <= OP_RUN;
            cnt_q   <= '0;
        end else if (abort_i) begin
            state_q <= OP_IDLE;
            cnt_q   <= '0;
        end else if (finish) begin
            state_q <= OP_DONE;
            cnt_q   <= '0;
        end else if (state_q == OP_RUN) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign state_o = state_q;
    assign done_o  = finish && !start_i && !abort_i;

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> state_q == OP_RUN); // R4
    AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OP_DONE && $past(state_q) != OP_DONE) |-> $past(state_q) == OP_RUN); // R4
    AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !start_i) |=> state_q == OP_IDLE); // R8
    AST_NO_IDLE_DONE_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OP_IDLE && !start_i) |=> state_q == OP_IDLE); // R4

endmodule

// File: rtl/rng_irq_ctrl.sv
// Module: sticky level interrupt for finished operations.
// Sets on an unmasked completion, clears on a clear command; a completion
// on the same edge as a clear keeps the line high.
module rng_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic done_evt_i,
    input  logic mask_done_i,
    input  logic clear_i,
    output logic irq_o
);
    logic irq_q;
    logic raise;

    // Unmasked completion in this cycle.
    assign raise = done_evt_i && !mask_done_i;

    // Interrupt flag: raise dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (raise) begin
            irq_q <= 1'b1;
        end else if (clear_i) begin
            irq_q <= 1'b0;
        end
    end

    assign irq_o = irq_q;

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(done_evt_i && !mask_done_i)); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !clear_i) |=> irq_q); // R6
    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !(done_evt_i && !mask_done_i)) |=> !irq_q); // R7
    AST_IRQ_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && done_evt_i && !mask_done_i) |=> irq_q); // R7

endmodule

// File: rtl/rng_lfsr.sv
// Module: 32-bit maximal-length Fibonacci LFSR used as the random word source.
// Steps once per advance pulse; feedback from bits 31, 21, 1, 0 into bit 0.
// Assumes SEED is nonzero.
module rng_lfsr #(
    parameter logic [31:0] SEED = 32'h0000_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv_i,
    output logic [31:0] value_o
);
    logic [31:0] state_q;
    logic        fb;

    // Feedback tap XOR.
    assign fb = state_q[31] ^ state_q[21] ^ state_q[1] ^ state_q[0];

    // Shift register update on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (adv_i) begin
            state_q <= {state_q[30:0], fb};
        end
    end

    assign value_o = state_q;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 32'h0); // R10
    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(state_q)); // R10

endmodule

// File: rtl/rng_ctrl_regs.sv
// Module: register front end of the random generator. Decodes bus writes into
// operation starts, clears and control updates, and multiplexes read data.
// Assumes single-cycle strobes, word-aligned offsets, and never rd and wr together.
module rng_ctrl_regs
    import rng_ctrl_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          OP_LATENCY = 16,
    parameter int          FIFO_WORDS = 5,
    parameter logic [31:0] LFSR_SEED  = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    localparam logic [3:0] FIFO_FIELD = 4'(FIFO_WORDS);

    logic                wr_cmd, wr_ctrl, rd_data;
    logic                sw_rst, clr_irq;
    logic [NUM_OPS-1:0]  op_start, op_done, op_run, op_fin;
    op_state_e           op_state [NUM_OPS];
    logic                mask_err_q, mask_done_q, auto_seed_q;
    logic [31:0]         rnd_word;
    logic [31:0]         cmd_rb, ctrl_rb, stat_rb;

    // Write and read strobes for each register.
    assign wr_cmd  = bus_wr && (bus_addr == ADDR_W'(OFF_CMD));
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
    assign rd_data = bus_rd && (bus_addr == ADDR_W'(OFF_DATA));

    // Command field decode.
    assign sw_rst  = wr_cmd && bus_wdata[CMD_SWRST];
    assign clr_irq = wr_cmd && (bus_wdata[CMD_CLRERR] || bus_wdata[CMD_CLRIRQ]);

    // One tracker per operation; command bit index equals operation index.
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        assign op_start[g] = wr_cmd && bus_wdata[g];

        rng_op_tracker #(.LATENCY(OP_LATENCY)) i_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (op_start[g]),
            .abort_i (sw_rst),
            .state_o (op_state[g]),
            .done_o  (op_done[g])
        );

        assign op_run[g] = (op_state[g] == OP_RUN);
        assign op_fin[g] = (op_state[g] == OP_DONE);
    end

    // Control register: exact write of the three kept bits, cleared by software reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_err_q  <= 1'b0;
            mask_done_q <= 1'b0;
            auto_seed_q <= 1'b0;
        end else if (sw_rst) begin
            mask_err_q  <= 1'b0;
            mask_done_q <= 1'b0;
            auto_seed_q <= 1'b0;
        end else if (wr_ctrl) begin
            mask_err_q  <= bus_wdata[CTL_MSKERR];
            mask_done_q <= bus_wdata[CTL_MSKDONE];
            auto_seed_q <= bus_wdata[CTL_AUTOSD];
        end
    end

    rng_irq_ctrl i_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_evt_i  (|op_done),
        .mask_done_i (mask_done_q),
        .clear_i     (clr_irq),
        .irq_o       (irq_o)
    );

    rng_lfsr #(.SEED(LFSR_SEED)) i_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (rd_data),
        .value_o (rnd_word)
    );

    // Readback words for the command, control and status registers.
    always_comb begin
        cmd_rb  = '0;
        cmd_rb[OP_SEED]  = op_run[OP_SEED];
        cmd_rb[OP_SELFT] = op_run[OP_SELFT];

        ctrl_rb = '0;
        ctrl_rb[CTL_MSKERR]  = mask_err_q;
        ctrl_rb[CTL_MSKDONE] = mask_done_q;
        ctrl_rb[CTL_AUTOSD]  = auto_seed_q;

        stat_rb = '0;
        stat_rb[15:12] = FIFO_FIELD;
        stat_rb[11:8]  = FIFO_FIELD;
        stat_rb[6]     = 1'b1;
        stat_rb[5]     = op_fin[OP_SEED];
        stat_rb[4]     = op_fin[OP_SELFT];
        stat_rb[1]     = |op_run;
        stat_rb[0]     = ~|op_run;
    end

    // Read data multiplexer by offset; unmapped offsets give zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_IDENT))     bus_rdata = IDENT_WORD;
        else if (bus_addr == ADDR_W'(OFF_CMD))  bus_rdata = cmd_rb;
        else if (bus_addr == ADDR_W'(OFF_CTRL)) bus_rdata = ctrl_rb;
        else if (bus_addr == ADDR_W'(OFF_STAT)) bus_rdata = stat_rb;
        else if (bus_addr == ADDR_W'(OFF_DATA)) bus_rdata = rnd_word;
    end

    AST_CMD_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFF_CMD)) |-> bus_rdata[31:2] == 30'h0); // R2
    AST_SWRST_CLEARS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> !mask_err_q && !mask_done_q && !auto_seed_q); // R8
    AST_BOTH_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && bus_wdata[1:0] == 2'b11) |=> (op_run == 2'b11)); // R2

endmodule

// File: tb/test_rng_ctrl_regs.sv
// Bench: scoreboard for the register front end. Driver tasks push expected
// read words into a queue; a monitor pops and compares at each read.
module test_rng_ctrl_regs;
    localparam int          L    = 6;
    localparam logic [31:0] SEED = 32'hACE1_0001;
    localparam logic [31:0] ST_IDLE = 32'h0000_5541;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] lfsr_m = SEED;

    rng_ctrl_regs #(.ADDR_W(8), .OP_LATENCY(L), .FIFO_WORDS(5), .LFSR_SEED(SEED)) i_rng_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic read_rnd(input string tag);
        bus_read(8'h14, lfsr_m, tag);
        lfsr_m = lfsr_next(lfsr_m);
    endtask

    task automatic check_irq(input logic e, input string tag);
        n_vec++;
        if (irq_o !== e) begin
            n_bad++;
            $display("FAIL %s irq actual %0b expected %0b", tag, irq_o, e);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // Monitor: compare read data against the scoreboard between edges.
    always @(negedge clk) begin
        if (rst_n && bus_rd) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: unexpected read, actual %h expected none", bus_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: all requirements, actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state and identification
        bus_read(8'h00, 32'h1000_0240, "R1 ident");
        bus_read(8'h04, 32'h0, "R2 cmd after reset");
        bus_read(8'h08, 32'h0, "R3 ctrl after reset");
        bus_read(8'h0C, ST_IDLE, "R5 status after reset");
        check_irq(1'b0, "R9 irq after reset");
        bus_read(8'h10, 32'h0, "R11 unmapped 0x10");
        bus_read(8'h1C, 32'h0, "R11 unmapped 0x1C");

        // Random data port
        read_rnd("R10 first word is seed");
        read_rnd("R10 second word");
        read_rnd("R10 third word");

        // Writes to read-only registers
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_write(8'h14, 32'h0000_1234);
        bus_read(8'h00, 32'h1000_0240, "R11 ident write ignored");
        bus_read(8'h0C, ST_IDLE, "R11 status write ignored");
        read_rnd("R11 data write ignored");

        // Control register
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_read(8'h08, 32'h70, "R3 ctrl all ones");
        bus_write(8'h08, 32'h0000_0050);
        bus_read(8'h08, 32'h50, "R3 ctrl 0x50");
        bus_write(8'h08, 32'h0);
        bus_read(8'h08, 32'h0, "R3 ctrl cleared");

        // Seed run with exact completion edge
        bus_write(8'h04, 32'h02);
        bus_read(8'h04, 32'h2, "R2 seed running flag");
        bus_read(8'h0C, 32'h0000_5542, "R5 busy while seeding");
        wait_cycles(L - 3);
        check_irq(1'b0, "R6 irq low before completion");
        bus_read(8'h0C, 32'h0000_5542, "R4 still busy one edge before done");
        check_irq(1'b1, "R6 irq on seed completion");
        bus_read(8'h0C, 32'h0000_5561, "R5 seed done status");
        bus_read(8'h04, 32'h0, "R2 cmd idle after seed");
        wait_cycles(4);
        check_irq(1'b1, "R6 irq sticky");
        bus_write(8'h04, 32'h10);
        check_irq(1'b0, "R7 clear-interrupt lowers irq");

        // Self-test run, cleared by clear-error
        bus_write(8'h04, 32'h01);
        wait_cycles(L - 1);
        check_irq(1'b0, "R4 self-test not yet done");
        wait_cycles(1);
        check_irq(1'b1, "R4 self-test done after latency");
        bus_read(8'h0C, 32'h0000_5571, "R5 both done");
        bus_write(8'h04, 32'h20);
        check_irq(1'b0, "R7 clear-error lowers irq");

        // Both starts in one write
        bus_write(8'h04, 32'h03);
        bus_read(8'h04, 32'h3, "R2 both running");
        bus_read(8'h0C, 32'h0000_5542, "R5 busy both running");
        wait_cycles(L);
        bus_read(8'h0C, 32'h0000_5571, "R5 both done again");
        check_irq(1'b1, "R6 irq after dual run");
        bus_write(8'h04, 32'h10);

        // Restart while running
        bus_write(8'h04, 32'h01);
        wait_cycles(3);
        bus_write(8'h04, 32'h01);
        wait_cycles(L - 1);
        bus_read(8'h04, 32'h1, "R4 restart extends run");
        bus_read(8'h04, 32'h0, "R4 restarted run finishes");
        check_irq(1'b1, "R6 irq after restarted run");
        bus_write(8'h04, 32'h10);

        // Masked completion
        bus_write(8'h08, 32'h20);
        bus_write(8'h04, 32'h02);
        wait_cycles(L + 2);
        bus_read(8'h0C, 32'h0000_5571, "R5 masked seed done");
        check_irq(1'b0, "R6 mask-done suppresses irq");

        // Clear colliding with completion
        bus_write(8'h08, 32'h0);
        bus_write(8'h04, 32'h02);
        wait_cycles(L - 1);
        bus_write(8'h04, 32'h10);
        check_irq(1'b1, "R7 completion wins over clear");
        bus_write(8'h04, 32'h10);
        check_irq(1'b0, "R7 later clear works");

        // Software reset
        bus_write(8'h04, 32'h01);
        wait_cycles(L + 1);
        check_irq(1'b1, "R6 irq before software reset");
        bus_write(8'h08, 32'h70);
        bus_write(8'h04, 32'h40);
        bus_read(8'h08, 32'h0, "R8 software reset clears ctrl");
        bus_read(8'h0C, ST_IDLE, "R8 software reset idles ops");
        check_irq(1'b1, "R8 software reset keeps irq");

        bus_write(8'h08, 32'h10);
        bus_write(8'h04, 32'h42);
        bus_read(8'h04, 32'h2, "R8 seed starts with software reset");
        bus_read(8'h08, 32'h0, "R8 ctrl cleared with combined write");
        wait_cycles(L);
        bus_read(8'h0C, 32'h0000_5561, "R8 seed completes after combined write");

        bus_write(8'h04, 32'h01);
        bus_write(8'h04, 32'h40);
        bus_read(8'h0C, ST_IDLE, "R8 software reset aborts running op");
        bus_read(8'h04, 32'h0, "R8 no running flags after abort");

        // Hardware reset mid-operation
        bus_write(8'h08, 32'h30);
        bus_write(8'h04, 32'h03);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        lfsr_m = SEED;
        check_irq(1'b0, "R9 irq cleared by reset");
        bus_read(8'h08, 32'h0, "R9 ctrl cleared by reset");
        bus_read(8'h0C, ST_IDLE, "R9 ops idle after reset");
        bus_read(8'h04, 32'h0, "R9 cmd idle after reset");
        read_rnd("R9 generator reloads seed");
        read_rnd("R10 step after reload");

        @(posedge clk); #1;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule